// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block acts as the target side of a three-wire serial memory bus: a select line, a serial clock and a serial data input, with a serial data output and its enable. It stores 64 sixteen-bit words in on-chip registers. It decodes a start bit, a two-bit opcode and a six-bit address. It supports single-word read, write and erase, whole-array write and erase, and a pair of commands that arm and disarm array modification. It serves as a well-behaved partner for a bus master inside the same chip, or as a stand-in for a real part in system tests.

The bus inputs are oversampled on the system clock. Select and data pass through a synchroniser. The serial clock is synchronised too, and its rising edge is detected. All protocol state advances on those detected edges. Programming delays and ready/busy signalling are not modelled: every array change takes effect in the system clock cycle that follows the edge completing the command.

Top module: `mw_eeprom_model`

## Requirements
- R1: After reset every word reads 16'hFFFF, the modify-enable latch is clear, and `bus_dout_en` is low.
- R2: With select high, the block ignores zeros on the data line. The first 1 sampled at a serial-clock rising edge is the start bit. The next 8 bits, MSB first, are a 2-bit opcode followed by a 6-bit address.
- R3: Opcode 2'b10 reads a word. After the rising edge that samples the last address bit, `bus_dout` carries data bit 15. Each later rising edge presents the next lower bit, so 16 bits are sent MSB first.
- R4: Opcode 2'b01 is followed by 16 data bits, MSB first. The addressed word takes this value on the 16th data bit, provided the modify-enable latch is set.
- R5: Opcode 2'b11 sets the addressed word to 16'hFFFF and leaves every other word unchanged.
- R6: With opcode 2'b00, the top two address bits select a sub-command. 2'b11 sets the modify-enable latch and 2'b00 clears it.
- R7: With opcode 2'b00, sub-command 2'b10 sets all words to 16'hFFFF. Sub-command 2'b01, followed by 16 data bits, writes that value into all words.
- R8: While the latch is clear, single write, single erase, erase-all and write-all leave the array unchanged.
- R9: Dropping select at any point abandons the transaction in progress and returns the block to waiting for a start bit. No partial write takes effect.
- R10: `bus_dout_en` is high only during the 16-bit read data phase and falls on the rising edge after bit 0. `bus_dout` is 0 whenever it is not enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Device select, active high |
| bus_clk | input | 1 | Serial clock from the master |
| bus_din | input | 1 | Serial data from the master |
| bus_dout | output | 1 | Serial read data to the master |
| bus_dout_en | output | 1 | Output enable for `bus_dout` |

## Verification
The bench fills all 64 addresses with an address-derived pattern and reads each word back. A design with an off-by-one bit count or swapped bit order would return rotated or mirrored data. It sends commands while the latch is disarmed. A block that ignored the latch would then show changed words on read-back. It drops select in the middle of a write's data bits, which exposes a design that commits partial data or fails to resynchronise on the next start bit. It also checks that leading zeros do not count as a start bit, that erasing one word leaves its neighbours intact, and that the output enable falls exactly one edge after the last read bit.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_DATA = 3'd2,
    ST_READ = 3'd3,
    ST_HOLD = 3'd4
  } mw_state_t;

  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_DISARM = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLEAR  = 2'b10;
  localparam logic [1:0] SUB_ARM    = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_a,
  input  logic sclk_a,
  input  logic din_a,
  output logic sel_s,
  output logic din_s,
  output logic sclk_rise
);
  logic [STAGES-1:0] sel_q, sclk_q, din_q;
  logic              sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '0;
      sclk_q      <= '0;
      din_q       <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sel_q       <= {sel_q[STAGES-2:0], sel_a};
      sclk_q      <= {sclk_q[STAGES-2:0], sclk_a};
      din_q       <= {din_q[STAGES-2:0], din_a};
      sclk_prev_q <= sclk_q[STAGES-1];
    end
  end

  assign sel_s     = sel_q[STAGES-1];
  assign din_s     = din_q[STAGES-1];
  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_prev_q;
endmodule

// File: rtl/mw_decoder.sv
module mw_decoder
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              din_i,
  input  logic              sk_rise_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_stb_o,
  output logic              fill_o,
  output logic              er_stb_o,
  output logic              clr_stb_o,
  output logic              wen_o,
  output logic              dout_o,
  output logic              dout_en_o
);
  localparam int INSTR_W = ADDR_W + 2;
  localparam int CNT_W   = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_W - 1);

  mw_state_t         state_q, n_state;
  logic [CNT_W-1:0]  cnt_q, n_cnt;
  logic [DATA_W-1:0] in_sr_q, n_in_sr;
  logic [DATA_W-1:0] out_sr_q, n_out_sr;
  logic [ADDR_W-1:0] addr_q, n_addr;
  logic              wen_q, n_wen;
  logic              all_q, n_all;
  logic              oe_q, n_oe;
  logic [INSTR_W-1:0] instr;

  assign instr = {in_sr_q[INSTR_W-2:0], din_i};

  always_comb begin
    n_state   = state_q;
    n_cnt     = cnt_q;
    n_in_sr   = in_sr_q;
    n_out_sr  = out_sr_q;
    n_addr    = addr_q;
    n_wen     = wen_q;
    n_all     = all_q;
    n_oe      = oe_q;
    wr_stb_o  = 1'b0;
    er_stb_o  = 1'b0;
    clr_stb_o = 1'b0;
    if (!sel_i) begin
      n_state = ST_IDLE;
      n_cnt   = '0;
      n_oe    = 1'b0;
    end else if (sk_rise_i) begin
      case (state_q)
        ST_IDLE: begin
          if (din_i) begin
            n_state = ST_CMD;
            n_cnt   = '0;
          end
        end
        ST_CMD: begin
          n_in_sr = {in_sr_q[DATA_W-2:0], din_i};
          n_cnt   = cnt_q + 1'b1;
          if (cnt_q == LAST_INSTR) begin
            n_cnt   = '0;
            n_addr  = instr[ADDR_W-1:0];
            n_state = ST_HOLD;
            case (instr[INSTR_W-1 -: 2])
              OP_READ: begin
                n_state  = ST_READ;
                n_out_sr = rd_data_i;
                n_oe     = 1'b1;
              end
              OP_WRITE: begin
                n_state = ST_DATA;
                n_all   = 1'b0;
              end
              OP_ERASE: er_stb_o = 1'b1;
              default: begin
                case (instr[ADDR_W-1 -: 2])
                  SUB_ARM:    n_wen     = 1'b1;
                  SUB_DISARM: n_wen     = 1'b0;
                  SUB_CLEAR:  clr_stb_o = 1'b1;
                  default: begin
                    n_state = ST_DATA;
                    n_all   = 1'b1;
                  end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          n_in_sr = {in_sr_q[DATA_W-2:0], din_i};
          n_cnt   = cnt_q + 1'b1;
          if (cnt_q == LAST_DATA) begin
            wr_stb_o = 1'b1;
            n_cnt    = '0;
            n_state  = ST_HOLD;
          end
        end
        ST_READ: begin
          if (cnt_q == LAST_DATA) begin
            n_oe    = 1'b0;
            n_cnt   = '0;
            n_state = ST_HOLD;
          end else begin
            n_out_sr = {out_sr_q[DATA_W-2:0], 1'b0};
            n_cnt    = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      in_sr_q  <= '0;
      out_sr_q <= '0;
      addr_q   <= '0;
      wen_q    <= 1'b0;
      all_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= n_state;
      cnt_q    <= n_cnt;
      in_sr_q  <= n_in_sr;
      out_sr_q <= n_out_sr;
      addr_q   <= n_addr;
      wen_q    <= n_wen;
      all_q    <= n_all;
      oe_q     <= n_oe;
    end
  end

  assign acc_addr_o = (state_q == ST_CMD) ? instr[ADDR_W-1:0] : addr_q;
  assign wdata_o    = {in_sr_q[DATA_W-2:0], din_i};
  assign fill_o     = all_q;
  assign wen_o      = wen_q;
  assign dout_en_o  = oe_q;
  assign dout_o     = oe_q & out_sr_q[DATA_W-1];

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> (state_q == ST_IDLE && cnt_q == '0));
  // R10
  oe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(sk_rise_i && sel_i));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q);
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD) |-> (cnt_q <= LAST_INSTR));
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_stb_i,
  input  logic              fill_i,
  input  logic              er_stb_i,
  input  logic              clr_stb_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit, do_wr, do_er;
    logic [DATA_W-1:0] n_word;
    assign hit   = (addr_i == ADDR_W'(i));
    assign do_wr = wen_i & wr_stb_i & (fill_i | hit);
    assign do_er = wen_i & (clr_stb_i | (er_stb_i & hit));

    always_comb begin
      n_word = mem_q[i];
      if (do_er)      n_word = '1;
      else if (do_wr) n_word = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              mem_q[i] <= '1;
      else if (do_wr | do_er)  mem_q[i] <= n_word;
    end
  end

  assign rd_data_o = mem_q[addr_i];

  // R8
  locked_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_i |=> $stable(mem_q));
  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb_i && wen_i) |=> (mem_q == '1));
endmodule

// File: rtl/mw_eeprom_model.sv
module mw_eeprom_model #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_sel,
  input  logic bus_clk,
  input  logic bus_din,
  output logic bus_dout,
  output logic bus_dout_en
);
  logic              sel_s, din_s, sk_rise;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] wdata, rd_data;
  logic              wr_stb, fill, er_stb, clr_stb, wen;

  mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_a     (bus_sel),
    .sclk_a    (bus_clk),
    .din_a     (bus_din),
    .sel_s     (sel_s),
    .din_s     (din_s),
    .sclk_rise (sk_rise)
  );

  mw_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_s),
    .din_i      (din_s),
    .sk_rise_i  (sk_rise),
    .rd_data_i  (rd_data),
    .acc_addr_o (acc_addr),
    .wdata_o    (wdata),
    .wr_stb_o   (wr_stb),
    .fill_o     (fill),
    .er_stb_o   (er_stb),
    .clr_stb_o  (clr_stb),
    .wen_o      (wen),
    .dout_o     (bus_dout),
    .dout_en_o  (bus_dout_en)
  );

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wen_i     (wen),
    .addr_i    (acc_addr),
    .wdata_i   (wdata),
    .wr_stb_i  (wr_stb),
    .fill_i    (fill),
    .er_stb_i  (er_stb),
    .clr_stb_i (clr_stb),
    .rd_data_o (rd_data)
  );

  // R10
  deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> !bus_dout_en);
  // R10
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_dout_en |-> !bus_dout);
endmodule

// File: tb/tb_mw_eeprom_model.sv
module tb_mw_eeprom_model;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 5;
  localparam int DEPTH      = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, din = 1'b0;
  logic dout, doe;
  logic smp_do, smp_oe, early_oe;
  logic [15:0] model [DEPTH];
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_model dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_clk(sclk),
    .bus_din(din), .bus_dout(dout), .bus_dout_en(doe)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    @(negedge clk) din = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF-1) @(negedge clk);
    smp_do = dout;
    smp_oe = doe;
    @(negedge clk) sclk = 1'b0;
  endtask

  task automatic tx_start();
    @(negedge clk) sel = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic tx_end();
    @(negedge clk) begin sel = 1'b0; sclk = 1'b0; din = 1'b0; end
    repeat (6) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [5:0] a, input int zeros);
    logic [7:0] ins;
    ins = {op, a};
    tx_start();
    for (int z = 0; z < zeros; z++) clk_bit(1'b0);
    clk_bit(1'b1);
    early_oe = smp_oe;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(ins[i]);
      if (i > 0) early_oe = early_oe | smp_oe;
    end
  endtask

  task automatic rd(input logic [5:0] a, input int zeros, output logic [15:0] d, output logic oe_ok);
    send_cmd(2'b10, a, zeros);
    d[15] = smp_do;
    oe_ok = !early_oe && smp_oe;
    for (int i = 14; i >= 0; i--) begin
      clk_bit(1'b0);
      d[i] = smp_do;
      oe_ok = oe_ok && smp_oe;
    end
    clk_bit(1'b0);
    oe_ok = oe_ok && !smp_oe && !smp_do;
    tx_end();
    oe_ok = oe_ok && !doe;
  endtask

  task automatic data_bits(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) clk_bit(d[i]);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d);
    send_cmd(2'b01, a, 0); data_bits(d); tx_end();
  endtask

  task automatic do_erase(input logic [5:0] a);
    send_cmd(2'b11, a, 0); tx_end();
  endtask

  task automatic do_misc(input logic [1:0] sub);
    send_cmd(2'b00, {sub, 4'b1010}, 0); tx_end();
  endtask

  task automatic do_fill(input logic [15:0] d);
    send_cmd(2'b00, {2'b01, 4'b0110}, 0); data_bits(d); tx_end();
  endtask

  task automatic check_word(input logic [5:0] a, input string tag);
    logic [15:0] d;
    logic ok;
    rd(a, 0, d, ok);
    chk(d === model[a], tag, d, model[a]);
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < DEPTH; a++) check_word(6'(a), tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic ok;
    for (int a = 0; a < DEPTH; a++) model[a] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(doe === 1'b0, "R1 dout_en low after reset", {15'd0, doe}, 16'h0);
    check_word(6'd0, "R1 reset word 0");
    check_word(6'd63, "R1 reset word 63");

    rd(6'd7, 0, d, ok);
    chk(ok, "R10 enable only in data phase", {15'd0, ok}, 16'h1);

    do_write(6'd5, 16'h1234);
    check_word(6'd5, "R8 write with latch clear");

    do_misc(2'b11);
    do_write(6'd5, 16'h1234); model[5] = 16'h1234;
    check_word(6'd5, "R6 arm then write");

    for (int a = 0; a < DEPTH; a++) begin
      model[a] = 16'(a * 16'h0403) ^ 16'h5A3C;
      do_write(6'(a), model[a]);
    end
    check_all("R4 R3 address sweep");

    rd(6'd17, 3, d, ok);
    chk(d === model[17], "R2 leading zeros before start", d, model[17]);
    chk(ok, "R10 enable with leading zeros", {15'd0, ok}, 16'h1);

    do_erase(6'd20); model[20] = 16'hFFFF;
    check_word(6'd19, "R5 erase neighbour below");
    check_word(6'd20, "R5 erased word");
    check_word(6'd21, "R5 erase neighbour above");

    send_cmd(2'b01, 6'd30, 0);
    for (int i = 0; i < 10; i++) clk_bit(1'b0);
    tx_end();
    check_word(6'd30, "R9 aborted write");
    do_write(6'd30, 16'hBEEF); model[30] = 16'hBEEF;
    check_word(6'd30, "R9 write after abort");

    do_misc(2'b00);
    do_write(6'd31, 16'h0000);
    check_word(6'd31, "R8 write after disarm");
    do_erase(6'd31);
    check_word(6'd31, "R8 erase after disarm");
    send_cmd(2'b00, 6'b100000, 0); tx_end();
    check_word(6'd0, "R8 erase-all after disarm");
    do_fill(16'h0F0F);
    check_word(6'd1, "R8 write-all after disarm");

    do_misc(2'b11);
    do_fill(16'hC3A5);
    for (int a = 0; a < DEPTH; a++) model[a] = 16'hC3A5;
    check_all("R7 write-all");
    send_cmd(2'b00, 6'b100000, 0); tx_end();
    for (int a = 0; a < DEPTH; a++) model[a] = 16'hFFFF;
    check_all("R7 erase-all");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule